// File: doc/BRIEF.md
# Dual-Port Register Bank with Access Arbitration

A bank of byte-wide control registers shared by two independent access ports. Port A can read and write. Port B can only write. Each port presents its own address, strobes and data in every cycle. The block decides the outcome whenever both ports touch the bank in the same cycle. Accesses to different registers all take effect. A read of a register that is being written in the same cycle returns the value from before the write. If both ports write the same register in one cycle, port B's data is stored.

The serial engines that produce these strobes sit outside this block. The minimum strobe separation that gives a deterministic order is one system clock. A write strobed in cycle N is visible to a read strobed in cycle N+1 or later. A read strobed in cycle N or earlier sees the old contents. A read loads a holding register, and that register keeps its value until the next read strobe. Later writes therefore cannot change a byte that an engine is still shifting out.

Top module: `dual_port_regbank`

## Requirements
- R1: While rst_ni is low, every register is 0 and a_rdata_o is 0.
- R2: A port A write (a_wr_i=1) to an in-range address stores a_wdata_i there from the next clock edge.
- R3: A port B write (b_wr_i=1) to an in-range address stores b_wdata_i there from the next clock edge.
- R4: Writes from both ports in the same cycle to different addresses both take effect.
- R5: A read strobe (a_rd_i=1) in the same cycle as a write to the same address, from either port, returns the value held before that write.
- R6: A read strobe one or more cycles after a write to the same address returns the written value.
- R7: When both ports write the same address in the same cycle, the register takes b_wdata_i.
- R8: a_rdata_o takes the read result at the clock edge that samples a_rd_i and then holds it unchanged until the next read strobe, whatever writes occur in between.
- R9: Addresses at or above NUM_REGS (default 24) are outside the bank. Writes to them have no effect, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_rd_i | input | 1 | Port A read strobe |
| a_wr_i | input | 1 | Port A write strobe |
| a_addr_i | input | ADDR_W (5) | Port A register address |
| a_wdata_i | input | DATA_W (8) | Port A write data |
| a_rdata_o | output | DATA_W (8) | Port A read holding register |
| b_wr_i | input | 1 | Port B write strobe |
| b_addr_i | input | ADDR_W (5) | Port B register address |
| b_wdata_i | input | DATA_W (8) | Port B write data |

## Verification
A corrupted register, a lost write or a wrong collision winner shows up only at the next read of that address. It then appears on a_rdata_o one cycle after the read strobe. The stimulus therefore reads often and at random, so a bad register value surfaces within a few cycles. A fault in the holding register shows as a change of a_rdata_o in a cycle with no read strobe, and it appears at the very next edge.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned DEF_ADDR_W = 5;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_NUM_REGS = 24;
endpackage

// File: rtl/addr_decode.sv
module addr_decode #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned NUM_REGS = 24
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_REGS-1:0] hit_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign hit_o[i] = en_i && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/reg_store.sv
module reg_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 24
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [NUM_REGS-1:0]               a_hit_i,
  input  logic [DATA_W-1:0]                 a_wdata_i,
  input  logic [NUM_REGS-1:0]               b_hit_i,
  input  logic [DATA_W-1:0]                 b_wdata_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         regs_o[i] <= '0;
      else if (b_hit_i[i]) regs_o[i] <= b_wdata_i;  // write-only port has priority
      else if (a_hit_i[i]) regs_o[i] <= a_wdata_i;
    end
  end
endmodule

// File: rtl/read_hold.sv
module read_hold #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 24
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            rd_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0]               rdata_o
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_i == ADDR_W'(i)) sel = regs_i[i];
  end

  // captures pre-write contents: bank updates on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end
endmodule

// File: rtl/dual_port_regbank.sv
module dual_port_regbank
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_rd_i,
  input  logic              a_wr_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_wr_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i
);
  logic [NUM_REGS-1:0]             a_hit, b_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec_a (
    .en_i(a_wr_i), .addr_i(a_addr_i), .hit_o(a_hit));

  addr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec_b (
    .en_i(b_wr_i), .addr_i(b_addr_i), .hit_o(b_hit));

  reg_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_hit_i(a_hit), .a_wdata_i(a_wdata_i),
    .b_hit_i(b_hit), .b_wdata_i(b_wdata_i),
    .regs_o(regs));

  read_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(a_rd_i), .addr_i(a_addr_i),
    .regs_i(regs), .rdata_o(a_rdata_o));
endmodule

// File: rtl/dual_port_regbank_chk.sv
module dual_port_regbank_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_REGS = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_rd_i,
  input logic              a_wr_i,
  input logic [ADDR_W-1:0] a_addr_i,
  input logic [DATA_W-1:0] a_wdata_i,
  input logic [DATA_W-1:0] a_rdata_o,
  input logic              b_wr_i,
  input logic [ADDR_W-1:0] b_addr_i,
  input logic [DATA_W-1:0] b_wdata_i
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  // R1
  always @(negedge clk_i)
    if (!rst_ni) a_r1_reset_zero: assert (a_rdata_o == '0);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_rd_i |=> $stable(a_rdata_o));

  a_r9_oob_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_rd_i && {1'b0, a_addr_i} >= LIMIT) |=> a_rdata_o == '0);

  // R3, R6, R7: a B write is seen by a read strobed one cycle later
  a_r6_b_write_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_wr_i && {1'b0, b_addr_i} < LIMIT) ##1 (a_rd_i && a_addr_i == $past(b_addr_i))
    |=> a_rdata_o == $past(b_wdata_i, 2));

  // R2, R6: an uncontested A write is seen by a read one cycle later
  a_r2_a_write_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && !(b_wr_i && b_addr_i == a_addr_i) && {1'b0, a_addr_i} < LIMIT)
    ##1 (a_rd_i && a_addr_i == $past(a_addr_i))
    |=> a_rdata_o == $past(a_wdata_i, 2));
endmodule

bind dual_port_regbank dual_port_regbank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .a_rd_i(a_rd_i), .a_wr_i(a_wr_i),
  .a_addr_i(a_addr_i), .a_wdata_i(a_wdata_i), .a_rdata_o(a_rdata_o),
  .b_wr_i(b_wr_i), .b_addr_i(b_addr_i), .b_wdata_i(b_wdata_i));

// File: tb/sim_dual_port_regbank.sv
module sim_dual_port_regbank;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NR = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_rd = 0, a_wr = 0, b_wr = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wd = '0, b_wd = '0;
  logic [DW-1:0] a_rdata;

  int checks = 0, errors = 0;
  logic [DW-1:0] model [NR];
  logic [DW-1:0] exp_rd = '0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  dual_port_regbank u0 (
    .clk_i(clk), .rst_ni(rst_n), .a_rd_i(a_rd), .a_wr_i(a_wr),
    .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rdata),
    .b_wr_i(b_wr), .b_addr_i(b_addr), .b_wdata_i(b_wd));

  function automatic logic [DW-1:0] rd_model(input logic [AW-1:0] ad);
    return (int'(ad) < NR) ? model[ad] : '0;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a_rdata_o=%0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // check result of previous step, then drive this step and update model
  task automatic step(input string tag, input logic rd, input logic wa,
                      input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic wb, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    @(negedge clk);
    check(cur_tag, a_rdata, exp_rd);
    cur_tag = tag;
    a_rd = rd; a_wr = wa; a_addr = aa; a_wd = ad;
    b_wr = wb; b_addr = ba; b_wd = bd;
    if (rd) exp_rd = rd_model(aa);            // pre-write value (R5)
    if (wa && int'(aa) < NR) model[aa] = ad;
    if (wb && int'(ba) < NR) model[ba] = bd;  // B wins (R7)
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, '0, '0, 0, '0, '0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", a_rdata, '0);
    @(negedge clk) rst_n = 1'b1;
    // R1: bank is zero after reset
    step("R1", 1, 0, 5'd7, '0, 0, '0, '0);
    // R2 then R6
    step("R2", 0, 1, 5'd3, 8'hA5, 0, '0, '0);
    step("R6", 1, 0, 5'd3, '0, 0, '0, '0);
    // R3
    step("R3", 0, 0, '0, '0, 1, 5'd10, 8'h3C);
    step("R3", 1, 0, 5'd10, '0, 0, '0, '0);
    // R4: both ports, different addresses
    step("R4", 0, 1, 5'd1, 8'h11, 1, 5'd2, 8'h22);
    step("R4", 1, 0, 5'd1, '0, 0, '0, '0);
    step("R4", 1, 0, 5'd2, '0, 0, '0, '0);
    // R5: same-cycle read and B write
    step("R5", 1, 0, 5'd3, '0, 1, 5'd3, 8'h77);
    step("R6", 1, 0, 5'd3, '0, 0, '0, '0);
    // R5: same-cycle read and A write
    step("R5", 1, 1, 5'd10, 8'h99, 0, '0, '0);
    step("R6", 1, 0, 5'd10, '0, 0, '0, '0);
    // R7: double write
    step("R7", 0, 1, 5'd20, 8'hAA, 1, 5'd20, 8'hBB);
    step("R7", 1, 0, 5'd20, '0, 0, '0, '0);
    // R8: writes after read do not disturb holding register
    step("R8", 0, 1, 5'd20, 8'h01, 1, 5'd20, 8'h02);
    idle("R8");
    step("R8", 1, 0, 5'd20, '0, 0, '0, '0);
    // R9: out-of-range accesses
    step("R9", 0, 1, 5'd24, 8'hEE, 1, 5'd31, 8'hDD);
    step("R9", 1, 0, 5'd24, '0, 0, '0, '0);
    step("R9", 1, 0, 5'd31, '0, 0, '0, '0);
    for (int i = 0; i < NR; i++) step("R9", 1, 0, AW'(i), '0, 0, '0, '0);
    // random mix: R2 R3 R4 R5 R6 R7 R8 all exercised here
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] ra, rb;
      ra = AW'($urandom_range(0, 25));
      rb = ($urandom_range(0, 3) == 0) ? ra : AW'($urandom_range(0, 25));
      step("R5/R7 random", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ra,
           DW'($urandom), 1'($urandom_range(0, 1)), rb, DW'($urandom));
    end
    idle("R8");
    idle("R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule